// File: doc/BRIEF.md
# Byte-Stream Frame Aligner for STS-1 / STS-3c

This block watches a byte-aligned receive stream, one byte per clock when a valid strobe is high. It finds the unscrambled framing marker that opens every 125 microsecond frame, and from then on it tells downstream logic where each byte sits in the frame. Downstream overhead extractors use the row and column indices and the start-of-frame strobe to pick out the bytes they own. The in-frame and out-of-frame flags tell them whether those positions can be trusted.

A rate select picks between the single-lane rate (frame of 9 rows by 90 columns) and the concatenated three-lane rate (9 rows by 270 columns). At the single-lane rate the marker is one 0xF6 byte followed by one 0x28 byte. At the three-lane rate it is three 0xF6 bytes followed by three 0x28 bytes. After a marker is seen while hunting, the block runs a position counter that predicts the next marker. It confirms alignment on the predicted marker and drops it after repeated misses. Marker-like bytes at any other position are ignored once a position is predicted.

Top module: `frm_aligner`

## Requirements
- R1: After reset, sof is 0, row_idx and col_idx are 0, in_frame is 0 and oof is 1.
- R2: While hunting, the marker is 0xF6 then 0x28 when rate_3c is 0, and three 0xF6 followed by three 0x28 when rate_3c is 1, all on consecutive valid bytes. A partial marker does not start tracking. A full marker starts tracking, and oof stays 1.
- R3: While tracking, the byte after the marker is at row 0 and column 2 (rate_3c=0) or column 6 (rate_3c=1). The column steps by one per valid byte and wraps from 89 (or 269) to 0 of the next row. The row wraps from 8 to 0.
- R4: sof is high, together with byte_vld, exactly on the valid byte at row 0 and the column just past the marker. It is never high while hunting.
- R5: A full marker again at the predicted position in the frame after the one that started tracking sets in_frame to 1 and oof to 0, from the next byte on.
- R6: If the marker is missing at the first predicted position, the block returns to hunting.
- R7: While in frame, one to three consecutive frames with a wrong marker keep in_frame at 1 and sof still pulses at the predicted position. A correct marker clears the miss count.
- R8: The fourth consecutive wrong marker while in frame sets in_frame to 0 and oof to 1 and returns to hunting.
- R9: While in frame, a full marker at any position other than the predicted one changes neither the indices nor the flags.
- R10: While byte_vld is 0, row_idx, col_idx, in_frame and oof keep their values and sof is 0.
- R11: A change of rate_3c returns the block to hunting, with in_frame 0 and oof 1 from the next cycle.
- R12: While hunting, row_idx and col_idx read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_in | input | 8 | Received byte |
| byte_vld | input | 1 | byte_in holds a byte this cycle |
| rate_3c | input | 1 | 0: single-lane frame, 1: three-lane concatenated frame |
| sof | output | 1 | Start-of-frame strobe on the first byte after the marker |
| row_idx | output | 4 | Row of the byte on byte_in |
| col_idx | output | 9 | Column of the byte on byte_in |
| in_frame | output | 1 | Alignment confirmed |
| oof | output | 1 | Out of frame |

## Verification
The hardest state to reach from the ports is the edge of the loss counter. This is a run of exactly three bad markers while in frame, then a good one, then three more bad ones, all with in_frame still high. Only the next miss after that may drop alignment. The bench reaches it with a frame generator that can blank the marker of any chosen frame. It plays whole frames in the sequence needed and samples the flags on the byte that follows each predicted marker. The same generator can plant a stray marker in mid-frame and pause the valid strobe partway through a row.

// File: rtl/frm_align_pkg.sv
package frm_align_pkg;

  typedef enum logic [1:0] {
    SYNC_HUNT    = 2'd0,
    SYNC_PRESYNC = 2'd1,
    SYNC_LOCKED  = 2'd2
  } sync_state_t;

  // Number of interleaved lanes carried for a given rate.
  function automatic int lanes_for(input logic rate3c, input int mult);
    return rate3c ? mult : 1;
  endfunction

  // Columns per row for a given rate.
  function automatic int cols_for(input logic rate3c, input int cols1, input int mult);
    return cols1 * lanes_for(rate3c, mult);
  endfunction

  // Column of the first byte after the marker.
  function automatic int post_marker_col(input logic rate3c, input int mult);
    return 2 * lanes_for(rate3c, mult);
  endfunction

endpackage

// File: rtl/frm_pattern_det.sv
module frm_pattern_det
  import frm_align_pkg::*;
#(
  parameter int         MULT   = 3,
  parameter logic [7:0] A1_VAL = 8'hF6,
  parameter logic [7:0] A2_VAL = 8'h28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       rate3c,
  output logic       hit
);
  localparam int HIST = 2 * MULT - 1;

  logic [7:0] hist_q [HIST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < HIST; k++) hist_q[k] <= 8'h00;
    end else if (byte_vld) begin
      hist_q[0] <= byte_in;
      for (int k = 1; k < HIST; k++) hist_q[k] <= hist_q[k-1];
    end
  end

  // hist_q[0] is the newest stored byte; byte_in closes the marker.
  always_comb begin
    int  lanes;
    logic ok;
    lanes = lanes_for(rate3c, MULT);
    ok    = (byte_in == A2_VAL);
    for (int k = 0; k < HIST; k++) begin
      if (k < lanes - 1)          ok = ok & (hist_q[k] == A2_VAL);
      else if (k < 2 * lanes - 1) ok = ok & (hist_q[k] == A1_VAL);
    end
    hit = byte_vld & ok;
  end
endmodule

// File: rtl/frm_pos_counter.sv
module frm_pos_counter
  import frm_align_pkg::*;
#(
  parameter int ROWS  = 9,
  parameter int COLS1 = 90,
  parameter int MULT  = 3,
  parameter int ROW_W = 4,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic             rate3c,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             at_check,
  output logic             at_c1
);
  logic [COL_W-1:0] last_col, first_col;

  always_comb begin
    last_col  = COL_W'(cols_for(rate3c, COLS1, MULT) - 1);
    first_col = COL_W'(post_marker_col(rate3c, MULT));
    at_check  = (row_q == '0) && (col_q == first_col - COL_W'(1));
    at_c1     = (row_q == '0) && (col_q == first_col);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load) begin
      row_q <= '0;
      col_q <= first_col;
    end else if (adv) begin
      if (col_q == last_col) begin
        col_q <= '0;
        row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + ROW_W'(1);
      end else begin
        col_q <= col_q + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/frm_sync_fsm.sv
module frm_sync_fsm
  import frm_align_pkg::*;
#(
  parameter int CONFIRM = 2,
  parameter int LOSS    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        hit,
  input  logic        at_check,
  input  logic        rate_chg,
  output sync_state_t state_q,
  output logic        load,
  output logic        oof_q
);
  localparam int GW = $clog2(CONFIRM + 1);
  localparam int BW = $clog2(LOSS + 1);

  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;
  logic check_now, ev_lock, ev_drop, ev_loss, ev_miss;

  always_comb begin
    load      = (state_q == SYNC_HUNT) && hit && !rate_chg;
    check_now = adv && at_check && (state_q != SYNC_HUNT) && !rate_chg;
    ev_lock   = (state_q == SYNC_PRESYNC) && check_now && hit &&
                ((good_q + GW'(1)) >= GW'(CONFIRM));
    ev_drop   = (state_q == SYNC_PRESYNC) && check_now && !hit;
    ev_miss   = (state_q == SYNC_LOCKED) && check_now && !hit;
    ev_loss   = ev_miss && ((bad_q + BW'(1)) >= BW'(LOSS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rate_chg) begin
      state_q <= SYNC_HUNT;
      good_q  <= '0;
      bad_q   <= '0;
      oof_q   <= 1'b1;
    end else begin
      case (state_q)
        SYNC_HUNT: if (load) begin
          good_q  <= GW'(1);
          bad_q   <= '0;
          if (CONFIRM <= 1) begin
            state_q <= SYNC_LOCKED;
            oof_q   <= 1'b0;
          end else begin
            state_q <= SYNC_PRESYNC;
          end
        end
        SYNC_PRESYNC: begin
          if (ev_lock) begin
            state_q <= SYNC_LOCKED;
            oof_q   <= 1'b0;
            bad_q   <= '0;
          end else if (ev_drop) begin
            state_q <= SYNC_HUNT;
            good_q  <= '0;
          end else if (check_now) begin
            good_q  <= good_q + GW'(1);
          end
        end
        SYNC_LOCKED: begin
          if (ev_loss) begin
            state_q <= SYNC_HUNT;
            oof_q   <= 1'b1;
            bad_q   <= '0;
            good_q  <= '0;
          end else if (ev_miss) begin
            bad_q   <= bad_q + BW'(1);
          end else if (check_now) begin
            bad_q   <= '0;
          end
        end
        default: state_q <= SYNC_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/frm_aligner.sv
module frm_aligner
  import frm_align_pkg::*;
#(
  parameter logic [7:0] A1_BYTE        = 8'hF6,
  parameter logic [7:0] A2_BYTE        = 8'h28,
  parameter int         ROWS           = 9,
  parameter int         COLS_STS1      = 90,
  parameter int         STS3_MULT      = 3,
  parameter int         CONFIRM_FRAMES = 2,
  parameter int         LOSS_FRAMES    = 4,
  localparam int        ROW_W          = $clog2(ROWS),
  localparam int        COL_W          = $clog2(COLS_STS1 * STS3_MULT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       byte_in,
  input  logic             byte_vld,
  input  logic             rate_3c,
  output logic             sof,
  output logic [ROW_W-1:0] row_idx,
  output logic [COL_W-1:0] col_idx,
  output logic             in_frame,
  output logic             oof
);
  sync_state_t      sync_st;
  logic             rate_q, rate_chg, pat_hit, load_pos, oof_q;
  logic             at_check, at_c1, aligned;
  logic [ROW_W-1:0] pos_row;
  logic [COL_W-1:0] pos_col;

  always_ff @(posedge clk) begin
    if (!rst_n) rate_q <= 1'b0;
    else        rate_q <= rate_3c;
  end
  // After reset rate_q is 0, so a rate_3c held at 1 through reset costs one hunt restart.
  assign rate_chg = rst_n && (rate_3c != rate_q);

  frm_pattern_det #(
    .MULT(STS3_MULT), .A1_VAL(A1_BYTE), .A2_VAL(A2_BYTE)
  ) u_det (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .rate3c(rate_3c), .hit(pat_hit)
  );

  frm_pos_counter #(
    .ROWS(ROWS), .COLS1(COLS_STS1), .MULT(STS3_MULT), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(byte_vld), .load(load_pos), .rate3c(rate_3c),
    .row_q(pos_row), .col_q(pos_col), .at_check(at_check), .at_c1(at_c1)
  );

  frm_sync_fsm #(
    .CONFIRM(CONFIRM_FRAMES), .LOSS(LOSS_FRAMES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .adv(byte_vld), .hit(pat_hit), .at_check(at_check),
    .rate_chg(rate_chg), .state_q(sync_st), .load(load_pos), .oof_q(oof_q)
  );

  always_comb begin
    aligned  = (sync_st != SYNC_HUNT);
    row_idx  = aligned ? pos_row : '0;
    col_idx  = aligned ? pos_col : '0;
    sof      = byte_vld && aligned && at_c1 && !rate_chg;
    in_frame = (sync_st == SYNC_LOCKED);
    oof      = oof_q;
  end
endmodule

// File: rtl/frm_aligner_chk.sv
module frm_aligner_chk
  import frm_align_pkg::*;
#(
  parameter int ROWS      = 9,
  parameter int COLS_STS1 = 90,
  parameter int STS3_MULT = 3,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld,
  input logic             rate_3c,
  input logic             sof,
  input logic [ROW_W-1:0] row_idx,
  input logic [COL_W-1:0] col_idx,
  input logic             in_frame,
  input logic             oof,
  input sync_state_t      st,
  input logic             hit,
  input logic             rate_chg
);
  logic [COL_W-1:0] last_c;
  assign last_c = COL_W'(cols_for(rate_3c, COLS_STS1, STS3_MULT) - 1);

  AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SYNC_HUNT) |-> (!sof && row_idx == '0 && col_idx == '0)); // R12

  AST_LOCK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SYNC_HUNT && hit && !rate_chg) |=> (st != SYNC_HUNT && row_idx == '0 && oof)); // R2

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && in_frame && !rate_chg && col_idx != last_c)
      |=> (!in_frame || col_idx == $past(col_idx) + COL_W'(1))); // R3

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_idx) < ROWS); // R3

  AST_SOF_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (byte_vld && row_idx == '0)); // R4

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_frame && oof)); // R5

  AST_LOSS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_frame) |-> oof); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !rate_chg) |=> ($stable(row_idx) && $stable(col_idx) &&
                                  $stable(in_frame) && $stable(oof))); // R10

  AST_RATE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rate_chg |=> (oof && !in_frame)); // R11
endmodule

bind frm_aligner frm_aligner_chk #(
  .ROWS(ROWS), .COLS_STS1(COLS_STS1), .STS3_MULT(STS3_MULT), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .rate_3c(rate_3c), .sof(sof),
  .row_idx(row_idx), .col_idx(col_idx), .in_frame(in_frame), .oof(oof),
  .st(sync_st), .hit(pat_hit), .rate_chg(rate_chg)
);

// File: tb/tb_frm_aligner.sv
`timescale 1ns/1ps
module tb_frm_aligner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       byte_vld = 1'b0;
  logic       rate_3c = 1'b0;
  logic       sof, in_frame, oof;
  logic [3:0] row_idx;
  logic [8:0] col_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // observation of the byte just driven
  int o_sof, o_row, o_col, o_inf, o_oof;
  // per-frame captures
  int f_sof, f_row, f_col, f_inf, f_oof;
  int r1_row, r1_col, e_row, e_col, m_row, m_col, m_sof, m_inf;
  int s_row, s_col, s_sof, s_inf;

  always #10 clk = ~clk;

  frm_aligner dut (
    .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld), .rate_3c(rate_3c),
    .sof(sof), .row_idx(row_idx), .col_idx(col_idx), .in_frame(in_frame), .oof(oof)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sample();
    #2;
    o_sof = int'(sof); o_row = int'(row_idx); o_col = int'(col_idx);
    o_inf = int'(in_frame); o_oof = int'(oof);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_in = b; byte_vld = 1'b1;
    sample();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      byte_vld = 1'b0;
      sample();
    end
  endtask

  // One frame; good=0 blanks the marker, inj plants a stray marker in row 3,
  // stall pauses byte_vld before row 2 column 5.
  task automatic send_frame(input bit good, input bit inj, input bit stall);
    int lanes, cols;
    logic [7:0] b;
    lanes = rate_3c ? 3 : 1;
    cols  = 90 * lanes;
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < cols; c++) begin
        b = 8'h55;
        if (r == 0 && c < lanes)          b = good ? 8'hF6 : 8'h00;
        else if (r == 0 && c < 2 * lanes) b = good ? 8'h28 : 8'h00;
        if (inj && r == 3 && c >= 10 && c < 10 + lanes)                 b = 8'hF6;
        if (inj && r == 3 && c >= 10 + lanes && c < 10 + 2 * lanes)     b = 8'h28;
        if (stall && r == 2 && c == 5) begin
          idle(3);
          s_row = o_row; s_col = o_col; s_sof = o_sof; s_inf = o_inf;
        end
        send(b);
        if (r == 0 && c == 2 * lanes) begin
          f_sof = o_sof; f_row = o_row; f_col = o_col; f_inf = o_inf; f_oof = o_oof;
        end
        if (r == 1 && c == 0) begin r1_row = o_row; r1_col = o_col; end
        if (r == 8 && c == cols - 1) begin e_row = o_row; e_col = o_col; end
        if (inj && r == 3 && c == 10 + 2 * lanes) begin
          m_row = o_row; m_col = o_col; m_sof = o_sof; m_inf = o_inf;
        end
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    sample();
    chk("R1 sof", o_sof, 0);
    chk("R1 row", o_row, 0);
    chk("R1 col", o_col, 0);
    chk("R1 in_frame", o_inf, 0);
    chk("R1 oof", o_oof, 1);
  endtask

  task automatic t_lock_oc1();
    for (int i = 0; i < 7; i++) send(8'h55);
    chk("R12 hunt col", o_col, 0);
    send(8'hF6); send(8'hF6); send(8'h55);
    chk("R12 hunt after partial", o_col, 0);
    chk("R12 hunt sof", o_sof, 0);
    send_frame(1, 0, 0);
    chk("R2 tracking sof", f_sof, 1);
    chk("R3 first col oc1", f_col, 2);
    chk("R3 first row", f_row, 0);
    chk("R2 oof held", f_oof, 1);
    chk("R2 not in frame", f_inf, 0);
    chk("R3 row1 row", r1_row, 1);
    chk("R3 row1 col", r1_col, 0);
    chk("R3 last row", e_row, 8);
    chk("R3 last col", e_col, 89);
    send_frame(1, 0, 0);
    chk("R5 in_frame", f_inf, 1);
    chk("R5 oof", f_oof, 0);
    chk("R4 sof", f_sof, 1);
  endtask

  task automatic t_stray_and_stall();
    send_frame(1, 1, 1);
    chk("R9 stray row", m_row, 3);
    chk("R9 stray col", m_col, 12);
    chk("R9 stray sof", m_sof, 0);
    chk("R9 stray in_frame", m_inf, 1);
    chk("R10 stall row", s_row, 2);
    chk("R10 stall col", s_col, 5);
    chk("R10 stall sof", s_sof, 0);
    chk("R10 stall in_frame", s_inf, 1);
  endtask

  task automatic t_miss_count();
    for (int i = 0; i < 3; i++) begin
      send_frame(0, 0, 0);
      chk("R7 in_frame on miss", f_inf, 1);
      chk("R7 flywheel sof", f_sof, 1);
    end
    send_frame(1, 0, 0);
    chk("R7 in_frame on recovery", f_inf, 1);
    for (int i = 0; i < 3; i++) begin
      send_frame(0, 0, 0);
      chk("R7 miss count cleared", f_inf, 1);
    end
    send_frame(0, 0, 0);
    chk("R8 in_frame dropped", f_inf, 0);
    chk("R8 oof raised", f_oof, 1);
    chk("R8 sof in hunt", f_sof, 0);
    chk("R8 col in hunt", f_col, 0);
  endtask

  task automatic t_presync_drop();
    send_frame(1, 0, 0);
    chk("R6 tracking", f_sof, 1);
    send_frame(0, 0, 0);
    chk("R6 back to hunt sof", f_sof, 0);
    chk("R6 back to hunt col", f_col, 0);
    chk("R6 oof", f_oof, 1);
    send_frame(1, 0, 0);
    send_frame(1, 0, 0);
    chk("R5 relock", f_inf, 1);
  endtask

  task automatic t_rate_oc3();
    @(negedge clk); byte_vld = 1'b0; rate_3c = 1'b1;
    idle(1);
    chk("R11 in_frame", o_inf, 0);
    chk("R11 oof", o_oof, 1);
    chk("R11 col", o_col, 0);
    // single-lane marker is partial for three lanes
    send(8'hF6); send(8'hF6); send(8'h28); send(8'h28); send(8'h28); send(8'h55);
    chk("R2 partial oc3 sof", o_sof, 0);
    chk("R2 partial oc3 col", o_col, 0);
    send_frame(1, 0, 0);
    chk("R3 first col oc3", f_col, 6);
    chk("R4 sof oc3", f_sof, 1);
    chk("R3 oc3 row wrap row", r1_row, 1);
    chk("R3 oc3 row wrap col", r1_col, 0);
    chk("R3 oc3 last col", e_col, 269);
    send_frame(1, 0, 0);
    chk("R5 oc3 in_frame", f_inf, 1);
    chk("R5 oc3 oof", f_oof, 0);
  endtask

  initial begin
    t_reset();
    t_lock_oc1();
    t_stray_and_stall();
    t_miss_count();
    t_presync_drop();
    t_rate_oc3();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule